// File: doc/BRIEF.md
# Parallel ADC Acquisition Sequencer

This block sits on the host side of a 12-bit sampling converter with a parallel bus. It runs the converter in split-acquisition fashion. A single start request carries a mux channel, a power-down setting, an acquisition length and a timeout. The sequencer then performs two chip-select/write cycles. The first write opens the sampling window. The second write closes it and, on the rising edge of write, starts the conversion. The two control bytes differ only in their acquisition flag.

After the second write the sequencer watches the converter's active-low completion line. When that line falls, the sequencer runs one read cycle on the shared data bus and presents the captured word with a one-cycle valid strobe. If the line stays high for longer than the requested timeout, the sequence is abandoned and a one-cycle error strobe is raised instead. The data bus is split into an output word, an output enable and an input word, so that the tri-state buffer can live in the pad ring.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset, and whenever idle, `cs_n_o`, `wr_n_o` and `rd_n_o` are high, `bus_oe_o` is low, and `busy_o`, `valid_o` and `tmo_err_o` are low. The control word on `bus_o` has bits 11:8 zero, bits 7:6 equal to the clock-select parameter (default 2'b10, internal clock), bit 5 as the acquisition flag, bits 4:3 as the power-down code and bits 2:0 as the channel.
- R2: The first write of a sequence carries the acquisition flag set to 1, together with the channel and power-down code latched at start.
- R3: The second write carries the same word as the first, except that the acquisition flag is 0.
- R4: Counted between the end of the first write pulse and the start of the second, `wr_n_o` stays high for exactly HOLD_CYC plus the acquisition length latched at start cycles. A length of 0 is allowed.
- R5: Each write holds `cs_n_o` and `wr_n_o` low for WR_CYC cycles with `bus_oe_o` high. The bus stays driven for HOLD_CYC cycles after `wr_n_o` rises. Write and read strobes are never low together.
- R6: After the second write's hold, the sequencer samples `int_n_i` once per cycle, at most max(timeout,1) times, and starts no read before it sees the line low. A fall seen on the last allowed sample still leads to a read.
- R7: A read holds `cs_n_o` and `rd_n_o` low for RD_CYC cycles with `bus_oe_o` low. The word on `bus_i` in the last read cycle appears on `result_o`, with `valid_o` high for exactly one cycle in the cycle after the read.
- R8: If `int_n_i` is still high on the last allowed sample, no read is made, `valid_o` stays low, and `tmo_err_o` pulses for one cycle as the block returns to idle.
- R9: A start request that arrives while a sequence is running is ignored. The running sequence keeps its channel, and no second sequence follows it.
- R10: `busy_o` is high from the cycle after a start is accepted until the cycle in which `valid_o` or `tmo_err_o` is raised. In that cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| chan_i | input | 3 | Mux channel for the request |
| pd_i | input | 2 | Power-down code for the request |
| acq_len_i | input | ACQ_W | Extra acquisition cycles between the writes |
| tmo_i | input | TMO_W | Maximum number of completion-line samples |
| int_n_i | input | 1 | Converter completion flag, active low, synchronous to clk |
| bus_i | input | 12 | Data bus as seen by the host |
| bus_o | output | 12 | Control word driven onto the bus |
| bus_oe_o | output | 1 | Host drives the bus when high |
| cs_n_o | output | 1 | Converter chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 12 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| tmo_err_o | output | 1 | One-cycle strobe when the completion wait expires |

## Verification
The embedded assertions check, on every cycle, the following properties. Write and read never overlap, and the bus is driven throughout every write and released during every read. The request fields stay frozen while busy. The shared down-counter never wraps. The valid strobe lasts one cycle and never coincides with the error strobe.

The following can only be shown by the bench's sweep over all channels and power-down codes with several acquisition lengths: the actual bytes written, the exact pulse widths and acquisition gaps, and the returned data. The same applies to the exact boundary between a completion that just meets the timeout and one that misses it by a cycle, and to the rejection of a mid-sequence start.

// File: rtl/adc_seq_pkg.sv
// Package: shared layout of the converter control word and sequencer states.
// Assumes a 12-bit bus with the control byte carried on the low 8 bits.
package adc_seq_pkg;

    localparam int BUS_W  = 12;
    localparam int CHAN_W = 3;
    localparam int PD_W   = 2;
    localparam int CLK_W  = 2;

    // Control byte layout: clock select, acquisition flag, power-down, channel.
    typedef struct packed {
        logic [CLK_W-1:0]  clk_sel;
        logic              acq;
        logic [PD_W-1:0]   pd;
        logic [CHAN_W-1:0] chan;
    } ctrl_byte_t;

    localparam int CTRL_W = $bits(ctrl_byte_t);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W1_LOW,
        ST_W1_HOLD,
        ST_ACQ,
        ST_W2_LOW,
        ST_W2_HOLD,
        ST_WAIT,
        ST_READ
    } seq_state_t;

endpackage

// File: rtl/adc_seq_cnt.sv
// Module: loadable down-counter shared by every timed phase of the sequencer.
// Assumes load has priority. The counter saturates at zero, never wrapping.
module adc_seq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // Phase lengths (R4, R5) rely on the count only moving down between loads.
    assert_cnt_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/adc_seq_enc.sv
// Module: forms the 12-bit bus word for one control byte.
// Assumes upper bus bits are unused during writes and driven as zero.
module adc_seq_enc
    import adc_seq_pkg::*;
#(
    parameter logic [CLK_W-1:0] CLK_SEL = 2'b10,
    parameter bit               ACQ_BIT = 1'b1
) (
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [PD_W-1:0]   pd_i,
    output logic [BUS_W-1:0]  word_o
);

    ctrl_byte_t cb;

    // Pack the fields into the control byte and zero-extend to the bus.
    always_comb begin
        cb.clk_sel = CLK_SEL;
        cb.acq     = ACQ_BIT;
        cb.pd      = pd_i;
        cb.chan    = chan_i;
        word_o     = BUS_W'(cb);
    end

endmodule

// File: rtl/adc_acq_seq.sv
// Module: host-side sequencer for a parallel converter in split-acquisition use.
// It makes two writes (acquire, then convert), waits for the active-low
// completion line with a timeout, then makes one read and returns the word.
// Assumes int_n_i is already synchronous to clk and every *_CYC parameter is >= 1.
module adc_acq_seq
    import adc_seq_pkg::*;
#(
    parameter int               WR_CYC   = 2,
    parameter int               HOLD_CYC = 1,
    parameter int               RD_CYC   = 2,
    parameter int               ACQ_W    = 8,
    parameter int               TMO_W    = 12,
    parameter logic [CLK_W-1:0] CLK_SEL  = 2'b10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2:0]         chan_i,
    input  logic [1:0]         pd_i,
    input  logic [ACQ_W-1:0]   acq_len_i,
    input  logic [TMO_W-1:0]   tmo_i,
    input  logic               int_n_i,
    input  logic [11:0]        bus_i,
    output logic [11:0]        bus_o,
    output logic               bus_oe_o,
    output logic               cs_n_o,
    output logic               wr_n_o,
    output logic               rd_n_o,
    output logic               busy_o,
    output logic [11:0]        result_o,
    output logic               valid_o,
    output logic               tmo_err_o
);

    localparam int FLD_W = (ACQ_W > TMO_W) ? ACQ_W : TMO_W;
    localparam int CYC_W = $clog2(WR_CYC + HOLD_CYC + RD_CYC + 1);
    localparam int CNT_W = (FLD_W > CYC_W) ? FLD_W : CYC_W;
    localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);

    seq_state_t           state_q, state_d;
    logic [CHAN_W-1:0]    chan_q;
    logic [PD_W-1:0]      pd_q;
    logic [ACQ_W-1:0]     acq_q;
    logic [TMO_W-1:0]     tmo_q;
    logic                 ld;
    logic [CNT_W-1:0]     ld_val;
    logic                 cnt_zero;
    logic                 capture, expire;
    logic [BUS_W-1:0]     word [2];
    logic                 in_w1, in_w2;

    // One encoder per write phase: index 0 acquires, index 1 converts.
    for (genvar g = 0; g < 2; g++) begin : g_enc
        adc_seq_enc #(.CLK_SEL(CLK_SEL), .ACQ_BIT(g == 0)) i_enc (
            .chan_i (chan_q),
            .pd_i   (pd_q),
            .word_o (word[g])
        );
    end

    adc_seq_cnt #(.W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .val_i  (ld_val),
        .zero_o (cnt_zero)
    );

    // Next-state, counter reload and end-of-sequence events.
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        capture = 1'b0;
        expire  = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_W1_LOW; ld = 1'b1; ld_val = WR_LD;
            end
            ST_W1_LOW: if (cnt_zero) begin
                state_d = ST_W1_HOLD; ld = 1'b1; ld_val = HOLD_LD;
            end
            ST_W1_HOLD: if (cnt_zero) begin
                ld = 1'b1;
                if (acq_q == '0) begin
                    state_d = ST_W2_LOW; ld_val = WR_LD;
                end else begin
                    state_d = ST_ACQ; ld_val = CNT_W'(acq_q) - CNT_W'(1);
                end
            end
            ST_ACQ: if (cnt_zero) begin
                state_d = ST_W2_LOW; ld = 1'b1; ld_val = WR_LD;
            end
            ST_W2_LOW: if (cnt_zero) begin
                state_d = ST_W2_HOLD; ld = 1'b1; ld_val = HOLD_LD;
            end
            ST_W2_HOLD: if (cnt_zero) begin
                state_d = ST_WAIT; ld = 1'b1;
                ld_val = (tmo_q == '0) ? '0 : CNT_W'(tmo_q) - CNT_W'(1);
            end
            ST_WAIT: begin
                if (!int_n_i) begin
                    state_d = ST_READ; ld = 1'b1; ld_val = RD_LD;
                end else if (cnt_zero) begin
                    state_d = ST_IDLE; expire = 1'b1;
                end
            end
            ST_READ: if (cnt_zero) begin
                state_d = ST_IDLE; capture = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the request fields only when a start is accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            pd_q   <= '0;
            acq_q  <= '0;
            tmo_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            chan_q <= chan_i;
            pd_q   <= pd_i;
            acq_q  <= acq_len_i;
            tmo_q  <= tmo_i;
        end
    end

    // Capture the read word and raise the one-cycle result and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            tmo_err_o <= 1'b0;
        end else begin
            valid_o   <= capture;
            tmo_err_o <= expire;
            if (capture) result_o <= bus_i;
        end
    end

    // Bus strobes decoded from the registered state.
    always_comb begin
        in_w1    = (state_q == ST_W1_LOW) || (state_q == ST_W1_HOLD);
        in_w2    = (state_q == ST_W2_LOW) || (state_q == ST_W2_HOLD);
        bus_oe_o = in_w1 || in_w2;
        wr_n_o   = !((state_q == ST_W1_LOW) || (state_q == ST_W2_LOW));
        rd_n_o   = !(state_q == ST_READ);
        cs_n_o   = !(bus_oe_o || (state_q == ST_READ));
        busy_o   = (state_q != ST_IDLE);
        bus_o    = in_w1 ? word[0] : (in_w2 ? word[1] : '0);
    end

    assert_wr_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n_o && !rd_n_o));
    assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (bus_oe_o && !cs_n_o));
    assert_release_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !bus_oe_o);
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && tmo_err_o));
    assert_fields_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(chan_q) && $stable(pd_q) && $stable(acq_q)));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && wr_n_o && rd_n_o && !bus_oe_o));

endmodule

// File: tb/test_adc_acq_seq.sv
// Bench: converter model plus sweep of channels, power-down codes and gaps.
module test_adc_acq_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC = 2, HOLD_CYC = 1, RD_CYC = 2, ACQ_W = 8, TMO_W = 12;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2:0] chan = '0;
    logic [1:0] pd = '0;
    logic [ACQ_W-1:0] acq_len = '0;
    logic [TMO_W-1:0] tmo = '0;
    logic int_n = 1'b1;
    logic [11:0] bus_in = 12'hFFF;
    logic [11:0] bus_out, result;
    logic oe, cs_n, wr_n, rd_n, busy, valid, err;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // Converter model and bus monitor state.
    int nwr, wrlen, gap, holdcnt, rdlen, oe_bad, wcnt, conv_d;
    logic conv, prev_wr;
    logic [11:0] cur, wb0, wb1, mdata;
    int wl0, wl1;
    logic [8:0] seq_id = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_acq_seq #(.WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC),
                  .ACQ_W(ACQ_W), .TMO_W(TMO_W), .CLK_SEL(2'b10)) i_adc_acq_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .pd_i(pd),
        .acq_len_i(acq_len), .tmo_i(tmo), .int_n_i(int_n), .bus_i(bus_in),
        .bus_o(bus_out), .bus_oe_o(oe), .cs_n_o(cs_n), .wr_n_o(wr_n), .rd_n_o(rd_n),
        .busy_o(busy), .result_o(result), .valid_o(valid), .tmo_err_o(err));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        nwr = 0; wrlen = 0; gap = 0; holdcnt = 0; rdlen = 0; oe_bad = 0;
        wb0 = '0; wb1 = '0; wl0 = 0; wl1 = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Monitor and converter model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_wr = 1'b1; conv = 1'b0; int_n = 1'b1; bus_in = 12'hFFF;
        end else begin
            if (!wr_n) begin
                wrlen++; cur = bus_out;
                if (!oe || cs_n) oe_bad++;
            end
            if (!prev_wr && wr_n) begin
                if (nwr == 0) begin wb0 = cur; wl0 = wrlen; end
                if (nwr == 1) begin wb1 = cur; wl1 = wrlen; end
                wrlen = 0; nwr++;
                int_n = 1'b1;
                if (cur[5] == 1'b0) begin conv = 1'b1; wcnt = 0; end
            end
            if (wr_n && nwr == 1) gap++;
            if (wr_n && oe) holdcnt++;
            if (conv && cs_n) begin
                wcnt++;
                if (wcnt == conv_d) begin
                    int_n = 1'b0; conv = 1'b0;
                    mdata = {cur[2:0], seq_id};
                end
            end
            if (!rd_n) begin
                rdlen++; bus_in = mdata; int_n = 1'b1;
                if (oe) oe_bad++;
            end else begin
                bus_in = 12'hFFF;
            end
            prev_wr = wr_n;
        end
    end

    // One request; poke issues a conflicting start while busy.
    task automatic run_seq(input logic [2:0] c, input logic [1:0] p, input int a,
                           input int t, input int cd, input bit expect_ok, input bit poke);
        int waited;
        bit got_v, got_e;
        logic [11:0] e1, e2, exp_res;
        mon_clear();
        conv_d = cd;
        seq_id = seq_id + 9'd1;
        @(negedge clk);
        chan = c; pd = p; acq_len = ACQ_W'(a); tmo = TMO_W'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", busy, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            chan = ~c; pd = ~p; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0; got_v = 0; got_e = 0;
        while (!got_v && !got_e && waited < 2000) begin
            if (valid) got_v = 1;
            if (err) got_e = 1;
            if (!got_v && !got_e) begin @(negedge clk); waited++; end
        end
        e1 = {4'b0, 2'b10, 1'b1, p, c};
        e2 = {4'b0, 2'b10, 1'b0, p, c};
        exp_res = {c, seq_id};
        chk(busy === 1'b0, "R10 busy low at end", busy, 0);
        chk(wb0 == e1, "R2 first control word", wb0, e1);
        chk(wb1 == e2, "R3 second control word", wb1, e2);
        chk(gap == HOLD_CYC + a, "R4 acquisition gap", gap, HOLD_CYC + a);
        chk(wl0 == WR_CYC && wl1 == WR_CYC, "R5 write width", wl0 * 16 + wl1, WR_CYC * 17);
        chk(holdcnt == 2 * HOLD_CYC && oe_bad == 0, "R5 bus drive window",
            holdcnt, 2 * HOLD_CYC);
        if (expect_ok) begin
            chk(got_v && !got_e, "R6 read after completion", {got_v, got_e}, 2);
            chk(result == exp_res, "R7 result word", result, exp_res);
            chk(rdlen == RD_CYC, "R7 read width", rdlen, RD_CYC);
            @(negedge clk);
            chk(valid === 1'b0, "R7 valid one cycle", valid, 0);
        end else begin
            chk(got_e && !got_v, "R8 timeout strobe", {got_v, got_e}, 1);
            chk(rdlen == 0, "R8 no read on timeout", rdlen, 0);
            @(negedge clk);
            chk(err === 1'b0 && valid === 1'b0, "R8 error one cycle", {err, valid}, 0);
        end
        if (poke) begin
            repeat (12) @(negedge clk);
            chk(nwr == 2 && busy === 1'b0, "R9 ignored start", nwr, 2);
        end
    endtask

    initial begin
        mon_clear();
        conv_d = 3;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && wr_n === 1'b1 && rd_n === 1'b1 && oe === 1'b0,
            "R1 reset strobes", {cs_n, wr_n, rd_n, oe}, 4'b1110);
        chk(busy === 1'b0 && valid === 1'b0 && err === 1'b0,
            "R1 reset status", {busy, valid, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {cs_n, busy}, 2);

        // Sweep all channels and power-down codes over three gap lengths (R1-style layout checks).
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 4; p++)
                for (int ai = 0; ai < 3; ai++)
                    run_seq(3'(c), 2'(p), (ai == 0) ? 0 : (ai == 1) ? 1 : 5,
                            20, 2 + ((c + p) % 4), 1'b1, 1'b0);

        // Timeout boundaries: on the last allowed sample, and one cycle late (R6, R8).
        run_seq(3'd5, 2'd1, 2, 5, 5, 1'b1, 1'b0);
        run_seq(3'd5, 2'd1, 2, 5, 6, 1'b0, 1'b0);
        run_seq(3'd2, 2'd3, 0, 1, 1, 1'b1, 1'b0);
        run_seq(3'd2, 2'd3, 0, 1, 2, 1'b0, 1'b0);
        // A timeout of zero behaves as a single sample (R6).
        run_seq(3'd7, 2'd0, 1, 0, 1, 1'b1, 1'b0);
        run_seq(3'd7, 2'd0, 1, 0, 2, 1'b0, 1'b0);
        // Conflicting start while a sequence runs (R9).
        run_seq(3'd1, 2'd2, 3, 20, 4, 1'b1, 1'b1);
        run_seq(3'd6, 2'd0, 0, 20, 2, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule